// File: doc/BRIEF.md
# Conditional Relative Jump Resolver

This block resolves a single-word conditional jump. It takes the low field of the jump instruction, which holds a 3-bit condition selector and a signed word offset. It also takes the program counter value, which already points at the word after the jump, and the four status flags: negative, zero, carry and overflow. From these it decides whether the jump is taken and computes the relative target address.

A request is sampled on a clock edge when `start_i` is high and the unit is idle. The operands are captured on that edge. On the next edge the result registers are loaded and `done_o` rises for exactly one cycle. The latency is the same whether or not the jump is taken. On that second edge the unit's program counter register takes the target if the jump is taken. Otherwise it takes the fall-through address that came in with the request.

A new request may be sampled in the same cycle in which `done_o` is high, so jumps can be resolved back to back. Fetching the instruction and producing the flags are left to the surrounding pipeline.

Top module: `jump_resolve_unit`

## Requirements
- R1: The instruction field input holds the condition selector in bits 12:10 and a two's-complement word offset in bits 9:0.
- R2: Selector encodings: 0 = taken when Z is 0; 1 = taken when Z is 1; 2 = taken when C is 0; 3 = taken when C is 1; 4 = taken when N is 1; 7 = always taken.
- R3: Selector 5 (signed greater-or-equal) is taken when N XOR V is 0, and selector 6 (signed less-than) is taken when N XOR V is 1.
- R4: For a request sampled at clock edge k, `done_o` is high only in the cycle between edges k+1 and k+2. The timing does not depend on whether the jump is taken, and `busy_o` is high between edges k and k+1.
- R5: While `done_o` is high, `target_o` equals `pc_i + 2*sext(offset)` modulo 2^16, using the `pc_i` sampled with the request. This holds whether or not the jump is taken.
- R6: On the completion edge, `pc_o` loads `target_o` if the jump is taken, or the sampled `pc_i` if it is not. At no other edge does `pc_o` change.
- R7: A `start_i` seen on an edge where `busy_o` is high is ignored and leaves the operands of the request in flight unchanged.
- R8: A `start_i` seen on the edge that raises `done_o` (the completion edge) is still ignored, but one seen on the following edge, while `done_o` is high, is accepted. This lets requests run back to back every two cycles.
- R9: After reset, `busy_o`, `done_o` and `taken_o` are 0, `target_o` is 0 and `pc_o` equals the RESET_PC parameter (default 0).
- R10: `taken_o` and `target_o` hold their last values until the next completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to resolve a jump |
| jfield_i | input | 13 | Condition selector (12:10) and word offset (9:0) |
| pc_i | input | 16 | Address of the word after the jump |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| busy_o | output | 1 | Request captured, result pending |
| done_o | output | 1 | One-cycle completion pulse |
| taken_o | output | 1 | Condition was met |
| target_o | output | 16 | Relative target address |
| pc_o | output | 16 | Program counter after the jump |

## Verification
Completion of one jump and acceptance of the next can fall in the same cycle. That happens when `start_i` is sampled on the edge that ends the `done_o` cycle. The bench provokes it by raising `start_i` while `done_o` is still high. It then checks that the second jump's result appears two edges later and that the first jump's result and program counter update were not disturbed. The opposite case, a `start_i` held during `busy_o`, is also checked: that request must be dropped, and the first jump's outcome must be the one that lands in `pc_o`.

// File: rtl/jru_pkg.sv
package jru_pkg;

  typedef enum logic [2:0] {
    JC_ZCLR   = 3'd0,
    JC_ZSET   = 3'd1,
    JC_CCLR   = 3'd2,
    JC_CSET   = 3'd3,
    JC_NSET   = 3'd4,
    JC_GE     = 3'd5,
    JC_LT     = 3'd6,
    JC_ALWAYS = 3'd7
  } jcond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/jru_decode.sv
module jru_decode
  import jru_pkg::*;
#(
  parameter int OFF_W  = 10,
  parameter int ADDR_W = 16,
  localparam int COND_W  = 3,
  localparam int FIELD_W = COND_W + OFF_W
) (
  input  logic [FIELD_W-1:0] field_i,
  output jcond_e             cond_o,
  output logic [ADDR_W-1:0]  disp_o
);

  logic [OFF_W-1:0] off_w;

  assign cond_o = jcond_e'(field_i[OFF_W +: COND_W]);
  assign off_w  = field_i[OFF_W-1:0];

  // byte displacement = word offset * 2, sign-extended to address width
  generate
    if (ADDR_W > OFF_W + 1) begin : g_ext
      assign disp_o = {{(ADDR_W-OFF_W-1){off_w[OFF_W-1]}}, off_w, 1'b0};
    end else begin : g_trunc
      logic [OFF_W:0] full_w;
      assign full_w = {off_w, 1'b0};
      assign disp_o = full_w[ADDR_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/jru_cond_eval.sv
module jru_cond_eval
  import jru_pkg::*;
(
  input  jcond_e cond_i,
  input  flags_t flags_i,
  output logic   taken_o
);

  logic sgn_lt;

  assign sgn_lt = flags_i.n ^ flags_i.v;

  always_comb begin
    unique case (cond_i)
      JC_ZCLR:   taken_o = ~flags_i.z;
      JC_ZSET:   taken_o = flags_i.z;
      JC_CCLR:   taken_o = ~flags_i.c;
      JC_CSET:   taken_o = flags_i.c;
      JC_NSET:   taken_o = flags_i.n;
      JC_GE:     taken_o = ~sgn_lt;
      JC_LT:     taken_o = sgn_lt;
      JC_ALWAYS: taken_o = 1'b1;
      default:   taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/jru_target.sv
module jru_target #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] disp_i,
  output logic [ADDR_W-1:0] target_o
);

  // modulo 2^ADDR_W: carry out discarded
  assign target_o = base_i + disp_i;

endmodule

// File: rtl/jru_ctrl.sv
module jru_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic capture_o,
  output logic complete_o,
  output logic busy_o,
  output logic done_o
);

  logic busy_q, busy_d;
  logic done_q, done_d;
  logic accept;

  assign accept = start_i & ~busy_q;

  always_comb begin
    busy_d = accept;
    done_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign capture_o  = accept;
  assign complete_o = busy_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  // R4: completion always one edge after capture
  a_r4_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> done_q);

  // R4: done is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: a request in flight blocks a second capture
  a_r7_no_recapture: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);

  // R8: a request presented during done is taken
  a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && start_i) |=> busy_q);

endmodule

// File: rtl/jump_resolve_unit.sv
module jump_resolve_unit
  import jru_pkg::*;
#(
  parameter int          OFF_W    = 10,
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] RESET_PC = 16'h0000,
  localparam int         FIELD_W  = 3 + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FIELD_W-1:0] jfield_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic               flag_n_i,
  input  logic               flag_z_i,
  input  logic               flag_c_i,
  input  logic               flag_v_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               taken_o,
  output logic [ADDR_W-1:0]  target_o,
  output logic [ADDR_W-1:0]  pc_o
);

  logic capture, complete;

  jcond_e             dec_cond;
  logic [ADDR_W-1:0]  dec_disp;
  flags_t             in_flags;

  jcond_e             cond_q,  cond_d;
  logic [ADDR_W-1:0]  disp_q,  disp_d;
  logic [ADDR_W-1:0]  base_q,  base_d;
  flags_t             flags_q, flags_d;

  logic               taken_c;
  logic [ADDR_W-1:0]  target_c;

  logic               taken_q,  taken_d;
  logic [ADDR_W-1:0]  target_q, target_d;
  logic [ADDR_W-1:0]  pc_q,     pc_d;

  assign in_flags = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};

  jru_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .capture_o  (capture),
    .complete_o (complete),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  jru_decode #(.OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_decode (
    .field_i (jfield_i),
    .cond_o  (dec_cond),
    .disp_o  (dec_disp)
  );

  // operand capture stage, enabled on accept
  always_comb begin
    cond_d  = cond_q;
    disp_d  = disp_q;
    base_d  = base_q;
    flags_d = flags_q;
    if (capture) begin
      cond_d  = dec_cond;
      disp_d  = dec_disp;
      base_d  = pc_i;
      flags_d = in_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q  <= JC_ZCLR;
      disp_q  <= '0;
      base_q  <= '0;
      flags_q <= '0;
    end else begin
      cond_q  <= cond_d;
      disp_q  <= disp_d;
      base_q  <= base_d;
      flags_q <= flags_d;
    end
  end

  jru_cond_eval u_eval (
    .cond_i  (cond_q),
    .flags_i (flags_q),
    .taken_o (taken_c)
  );

  jru_target #(.ADDR_W(ADDR_W)) u_target (
    .base_i   (base_q),
    .disp_i   (disp_q),
    .target_o (target_c)
  );

  // result stage, enabled on completion
  always_comb begin
    taken_d  = taken_q;
    target_d = target_q;
    pc_d     = pc_q;
    if (complete) begin
      taken_d  = taken_c;
      target_d = target_c;
      pc_d     = taken_c ? target_c : base_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q  <= 1'b0;
      target_q <= '0;
      pc_q     <= RESET_PC[ADDR_W-1:0];
    end else begin
      taken_q  <= taken_d;
      target_q <= target_d;
      pc_q     <= pc_d;
    end
  end

  assign taken_o  = taken_q;
  assign target_o = target_q;
  assign pc_o     = pc_q;

  // R6: program counter follows the resolved outcome
  a_r6_pc_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pc_o == (taken_o ? target_o : base_q)));

  // R6: program counter only moves on a completion edge
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(pc_o) || $past(busy_o));

  // R5: displacement is whole words, so target parity matches base
  a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (target_o[0] == base_q[0]));

  // R10: outputs frozen outside completion
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> ($stable(taken_o) && $stable(target_o)));

endmodule

// File: tb/jump_resolve_unit_tb.sv
module jump_resolve_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [12:0] jfield_i;
  logic [15:0] pc_i;
  logic        flag_n_i, flag_z_i, flag_c_i, flag_v_i;
  logic        busy_o, done_o, taken_o;
  logic [15:0] target_o, pc_o;

  int total = 0;
  int bad   = 0;
  logic [15:0] pc_model;

  jump_resolve_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .jfield_i (jfield_i),
    .pc_i     (pc_i),
    .flag_n_i (flag_n_i),
    .flag_z_i (flag_z_i),
    .flag_c_i (flag_c_i),
    .flag_v_i (flag_v_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .taken_o  (taken_o),
    .target_o (target_o),
    .pc_o     (pc_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {cond[2:0], off[9:0], pc[15:0], nzcv[3:0], expected_taken}
  localparam logic [33:0] VEC [16] = '{
    {3'd0, 10'h005, 16'h1000, 4'b0000, 1'b1},
    {3'd0, 10'h005, 16'h1000, 4'b0100, 1'b0},
    {3'd1, 10'h3FF, 16'h2002, 4'b0100, 1'b1},
    {3'd1, 10'h3FF, 16'h2002, 4'b1011, 1'b0},
    {3'd2, 10'h1FF, 16'hFFF0, 4'b1101, 1'b1},
    {3'd2, 10'h1FF, 16'hFFF0, 4'b0010, 1'b0},
    {3'd3, 10'h200, 16'h0004, 4'b0010, 1'b1},
    {3'd3, 10'h200, 16'h0004, 4'b1101, 1'b0},
    {3'd4, 10'h010, 16'h8000, 4'b1000, 1'b1},
    {3'd4, 10'h010, 16'h8000, 4'b0111, 1'b0},
    {3'd5, 10'h020, 16'h0100, 4'b1001, 1'b1},
    {3'd5, 10'h020, 16'h0100, 4'b1000, 1'b0},
    {3'd6, 10'h3F0, 16'h0010, 4'b0001, 1'b1},
    {3'd6, 10'h3F0, 16'h0010, 4'b1001, 1'b0},
    {3'd7, 10'h000, 16'h4444, 4'b0000, 1'b1},
    {3'd7, 10'h155, 16'hABCE, 4'b1111, 1'b1}
  };

  function automatic logic [15:0] exp_target(logic [9:0] off, logic [15:0] pc);
    logic [15:0] d;
    d = {{5{off[9]}}, off, 1'b0};
    return pc + d;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] c, logic [9:0] off, logic [15:0] pc, logic [3:0] nzcv);
    jfield_i = {c, off};
    pc_i     = pc;
    {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = nzcv;
  endtask

  // request at next edge, check result two edges later
  task automatic run_one(logic [2:0] c, logic [9:0] off, logic [15:0] pc,
                         logic [3:0] nzcv, logic exp_tk, string req);
    logic [15:0] tgt;
    tgt = exp_target(off, pc);
    drive(c, off, pc, nzcv);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R4 busy", {31'd0, busy_o}, 32'd1);
    chk("R4 no early done", {31'd0, done_o}, 32'd0);
    @(negedge clk);
    chk("R4 done", {31'd0, done_o}, 32'd1);
    chk(req, {31'd0, taken_o}, {31'd0, exp_tk});
    chk("R5 target", {16'd0, target_o}, {16'd0, tgt});
    pc_model = exp_tk ? tgt : pc;
    chk("R6 pc", {16'd0, pc_o}, {16'd0, pc_model});
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    drive(3'd0, 10'd0, 16'd0, 4'd0);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 busy", {31'd0, busy_o}, 32'd0);
    chk("R9 done", {31'd0, done_o}, 32'd0);
    chk("R9 taken", {31'd0, taken_o}, 32'd0);
    chk("R9 target", {16'd0, target_o}, 32'd0);
    chk("R9 pc", {16'd0, pc_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 16; i++) begin
      run_one(VEC[i][33:31], VEC[i][30:21], VEC[i][20:5], VEC[i][4:1], VEC[i][0],
              (VEC[i][33:31] == 3'd5 || VEC[i][33:31] == 3'd6) ? "R3 taken" : "R2 taken");
    end

    // R10: results hold while idle; R4 pulse ends
    begin
      logic        tk;
      logic [15:0] tg;
      tk = taken_o;
      tg = target_o;
      drive(3'd0, 10'h3AA, 16'h7777, 4'b0100);
      repeat (2) @(negedge clk);
      chk("R4 pulse ended", {31'd0, done_o}, 32'd0);
      chk("R10 taken hold", {31'd0, taken_o}, {31'd0, tk});
      chk("R10 target hold", {16'd0, target_o}, {16'd0, tg});
      chk("R6 pc idle hold", {16'd0, pc_o}, {16'd0, pc_model});
    end

    // R7: start held during busy is dropped
    drive(3'd1, 10'h008, 16'h0200, 4'b0100);
    start_i = 1'b1;
    @(negedge clk);
    drive(3'd7, 10'h100, 16'h4000, 4'b0000);
    @(negedge clk);
    start_i = 1'b0;
    chk("R7 first result kept", {16'd0, target_o}, {16'd0, exp_target(10'h008, 16'h0200)});
    chk("R7 pc from first", {16'd0, pc_o}, {16'd0, exp_target(10'h008, 16'h0200)});
    pc_model = exp_target(10'h008, 16'h0200);
    @(negedge clk);
    chk("R7 second not captured", {31'd0, busy_o}, 32'd0);
    chk("R7 no extra done", {31'd0, done_o}, 32'd0);
    @(negedge clk);
    chk("R7 pc unchanged", {16'd0, pc_o}, {16'd0, pc_model});

    // R8: new request during done is accepted
    drive(3'd2, 10'h3FE, 16'h0300, 4'b0000);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk("R8 first done", {31'd0, done_o}, 32'd1);
    chk("R8 first pc", {16'd0, pc_o}, {16'd0, exp_target(10'h3FE, 16'h0300)});
    drive(3'd4, 10'h040, 16'h0500, 4'b0000);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 second captured", {31'd0, busy_o}, 32'd1);
    chk("R8 gap cycle", {31'd0, done_o}, 32'd0);
    chk("R8 first pc kept", {16'd0, pc_o}, {16'd0, exp_target(10'h3FE, 16'h0300)});
    @(negedge clk);
    chk("R8 second done", {31'd0, done_o}, 32'd1);
    chk("R8 second not taken", {31'd0, taken_o}, 32'd0);
    chk("R8 second target", {16'd0, target_o}, {16'd0, exp_target(10'h040, 16'h0500)});
    chk("R8 second pc", {16'd0, pc_o}, 32'h0500);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R4 act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule